// File: doc/BRIEF.md
# Controller Output Decoder for a Multi-Cycle Processor

This block is the output half of a multi-cycle processor controller. It is purely combinational. It takes the one-hot cycle state (three fetch cycles and four execute cycles), the one-hot decoded instruction lines, three instruction-type flags and the instruction word. From these it produces every control line the datapath needs in the current cycle.

Those control lines are:
- the address and data register load enables;
- one write enable per general register;
- the shifter, ALU and carry-in function codes;
- the internal bus source select;
- the program counter input select;
- the register-read selection.

The outputs depend on both the state and the instruction, so the block forms the output logic of a Mealy machine. The state sequencer and the datapath are separate blocks. All enables are plain active-high levels.

Where an early or extra register load cannot disturb execution, the block uses the cheaper condition. The address register loads in every cycle where a later data-register load might need it. The data register loads in every third execute cycle.

Top module: `ctl_output_decode`

## Requirements
- R1: `mar_ld` is 1 when the state is F1, E1 or E2, whatever the instruction, and 0 in every other state.
- R2: `mdr_ld` is 1 in the following cases, and 0 otherwise:
  - in F2;
  - in E3 for any instruction;
  - in E2 when the instruction is LOAD.
- R3: The register write condition holds in the following cases:
  - in E4;
  - in E3 for LOAD, ADD, INC, DEC or COMP (bitwise complement);
  - in E2 for ASL, MOVE, CALL or CALLIND;
  - in E1 for CLEAR.

  While the condition holds, exactly bit `ir_word[23:20]` of `reg_we` is 1. Otherwise `reg_we` is all zero.
- R4: `shift_fn[1]` = ASR or ROR, and `shift_fn[0]` = ASL or ROR, in any state. Code 00 means pass-through.
- R5: `alu_fn` is 3'b111 in E2 for COMP or DEC. In E3 its bits are as follows:
  - bit 2 = COMP, OR or AND;
  - bit 1 = SUB, COMPARE, DEC, INC, ADD or AND;
  - bit 0 = DEC, INC, ADD or OR.

  In all other cases it is 0.
- R6: `carry_in` is 1 only for INC in E3.
- R7: `bus_sel` = {mask|mem, pc, alu|mem}, using these source paths:
  - pc = E2 with CALL or CALLIND;
  - mem = E4, or E3 with LOAD;
  - mask = E1 with LOAD, STORE or JUMP, or E3 with CALL;
  - alu = E1 with CLEAR, or E2/E3 with INC, DEC or COMP, or E3 with `ty_two`.
- R8: `rd_idx` is `ir_word[19:16]` in E1 when `ty_indirect` or `ty_two` is set, and `ir_word[23:20]` otherwise. `rd_from_bus` is 1 exactly in E2 with `ty_one`.
- R9: `pc_sel` is 1 in F1, or in E1 for CALL or CALLIND, and 0 otherwise.
- R10: Input encoding is as follows:
  - `st_oh` bits 0..6 are F1, F2, F3, E1, E2, E3, E4.
  - `op_oh` bits 0..24 are NOP, LOAD, STORE, LOADIND, STOREIND, MOVE, CLEAR, ADD, SUB, AND, OR, XOR, COMPARE, INC, DEC, COMP, ASL, ASR, ROR, JUMP, JUMPIND, CALL, CALLIND, RETURN, SKIP.

  With `st_oh` all zero, every state-gated output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| st_oh | input | 7 | One-hot cycle state |
| op_oh | input | 25 | One-hot decoded instruction |
| ty_indirect | input | 1 | Instruction uses an indirect operand |
| ty_one | input | 1 | One-operand instruction type |
| ty_two | input | 1 | Two-operand instruction type |
| ir_word | input | 32 | Instruction word (register fields) |
| mar_ld | output | 1 | Address register load enable |
| mdr_ld | output | 1 | Data register load enable |
| reg_we | output | 16 | Per-register write enables |
| pc_sel | output | 1 | Program counter input select |
| shift_fn | output | 2 | Shifter function |
| alu_fn | output | 3 | ALU function |
| carry_in | output | 1 | ALU carry input |
| bus_sel | output | 3 | Internal bus source select |
| rd_idx | output | 4 | Register index to read |
| rd_from_bus | output | 1 | Operand taken from the internal bus |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between any input and any output. The bench applies a new input set 1 ns after each rising edge. It compares all outputs against its own model at the following falling edge, half a period later, by which time the logic has settled. The stimulus sweeps every state, including none, against every instruction, including none, under all eight flag combinations. It uses a fresh instruction word each time, so both register fields and every destination index are covered.

// File: rtl/ctlout_pkg.sv
package ctlout_pkg;
  localparam int N_STATES = 7;
  localparam int ST_F1 = 0;
  localparam int ST_F2 = 1;
  localparam int ST_F3 = 2;
  localparam int ST_E1 = 3;
  localparam int ST_E2 = 4;
  localparam int ST_E3 = 5;
  localparam int ST_E4 = 6;

  localparam int N_OPS       = 25;
  localparam int OP_NOP      = 0;
  localparam int OP_LOAD     = 1;
  localparam int OP_STORE    = 2;
  localparam int OP_LOADIND  = 3;
  localparam int OP_STOREIND = 4;
  localparam int OP_MOVE     = 5;
  localparam int OP_CLEAR    = 6;
  localparam int OP_ADD      = 7;
  localparam int OP_SUB      = 8;
  localparam int OP_AND      = 9;
  localparam int OP_OR       = 10;
  localparam int OP_XOR      = 11;
  localparam int OP_COMPARE  = 12;
  localparam int OP_INC      = 13;
  localparam int OP_DEC      = 14;
  localparam int OP_COMP     = 15;
  localparam int OP_ASL      = 16;
  localparam int OP_ASR      = 17;
  localparam int OP_ROR      = 18;
  localparam int OP_JUMP     = 19;
  localparam int OP_JUMPIND  = 20;
  localparam int OP_CALL     = 21;
  localparam int OP_CALLIND  = 22;
  localparam int OP_RETURN   = 23;
  localparam int OP_SKIP     = 24;

  localparam int ALU_FN_W   = 3;
  localparam int SHIFT_FN_W = 2;
  localparam int BUS_SEL_W  = 3;
  localparam int BUS_ALU    = 0;
  localparam int BUS_PC     = 1;
  localparam int BUS_MASK   = 2;
endpackage

// File: rtl/ctlout_load_en.sv
module ctlout_load_en
  import ctlout_pkg::*;
#(
  parameter int IR_W    = 32,
  parameter int DST_LSB = 20,
  parameter int FLD_W   = 4,
  localparam int NREGS  = 1 << FLD_W
) (
  input  logic [N_STATES-1:0] st_oh,
  input  logic [N_OPS-1:0]    op_oh,
  input  logic [IR_W-1:0]     ir_word,
  output logic                mar_ld,
  output logic                mdr_ld,
  output logic [NREGS-1:0]    reg_we
);
  logic             wr_any;
  logic             wr_e3;
  logic             wr_e2;
  logic [FLD_W-1:0] dst;
  logic             unused_in;

  assign dst       = ir_word[DST_LSB +: FLD_W];
  assign unused_in = ^{ir_word, op_oh, st_oh};

  // Relaxed: address register may load in any of these cycles.
  assign mar_ld = st_oh[ST_F1] | st_oh[ST_E1] | st_oh[ST_E2];

  // Relaxed: a data-register load in every E3 is harmless.
  assign mdr_ld = st_oh[ST_F2] | st_oh[ST_E3] | (st_oh[ST_E2] & op_oh[OP_LOAD]);

  always_comb begin
    wr_e3 = op_oh[OP_LOAD] | op_oh[OP_ADD] | op_oh[OP_INC]
          | op_oh[OP_DEC]  | op_oh[OP_COMP];
    wr_e2 = op_oh[OP_ASL]  | op_oh[OP_MOVE] | op_oh[OP_CALL]
          | op_oh[OP_CALLIND];
    wr_any = st_oh[ST_E4]
           | (st_oh[ST_E3] & wr_e3)
           | (st_oh[ST_E2] & wr_e2)
           | (st_oh[ST_E1] & op_oh[OP_CLEAR]);
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_we
    assign reg_we[g] = wr_any & (dst == FLD_W'(g));
  end
endmodule

// File: rtl/ctlout_func.sv
module ctlout_func
  import ctlout_pkg::*;
(
  input  logic [N_STATES-1:0]   st_oh,
  input  logic [N_OPS-1:0]      op_oh,
  output logic [SHIFT_FN_W-1:0] shift_fn,
  output logic [ALU_FN_W-1:0]   alu_fn,
  output logic                  carry_in
);
  logic e2_unary;
  logic unused_in;

  assign unused_in = ^{st_oh, op_oh};

  assign shift_fn[1] = op_oh[OP_ASR] | op_oh[OP_ROR];
  assign shift_fn[0] = op_oh[OP_ASL] | op_oh[OP_ROR];

  always_comb begin
    e2_unary  = st_oh[ST_E2] & (op_oh[OP_COMP] | op_oh[OP_DEC]);
    alu_fn[2] = e2_unary
              | (st_oh[ST_E3] & (op_oh[OP_COMP] | op_oh[OP_OR] | op_oh[OP_AND]));
    alu_fn[1] = e2_unary
              | (st_oh[ST_E3] & (op_oh[OP_SUB] | op_oh[OP_COMPARE] | op_oh[OP_DEC]
                                 | op_oh[OP_INC] | op_oh[OP_ADD] | op_oh[OP_AND]));
    alu_fn[0] = e2_unary
              | (st_oh[ST_E3] & (op_oh[OP_DEC] | op_oh[OP_INC] | op_oh[OP_ADD]
                                 | op_oh[OP_OR]));
    carry_in  = st_oh[ST_E3] & op_oh[OP_INC];
  end
endmodule

// File: rtl/ctlout_sel.sv
module ctlout_sel
  import ctlout_pkg::*;
#(
  parameter int IR_W    = 32,
  parameter int DST_LSB = 20,
  parameter int SRC_LSB = 16,
  parameter int FLD_W   = 4
) (
  input  logic [N_STATES-1:0]  st_oh,
  input  logic [N_OPS-1:0]     op_oh,
  input  logic                 ty_indirect,
  input  logic                 ty_one,
  input  logic                 ty_two,
  input  logic [IR_W-1:0]      ir_word,
  output logic                 pc_sel,
  output logic [BUS_SEL_W-1:0] bus_sel,
  output logic [FLD_W-1:0]     rd_idx,
  output logic                 rd_from_bus
);
  logic path_pc;
  logic path_mem;
  logic path_mask;
  logic path_alu;
  logic calls;
  logic arith1;
  logic use_src;
  logic unused_in;

  assign unused_in = ^{ir_word, st_oh, op_oh};

  always_comb begin
    calls     = op_oh[OP_CALL] | op_oh[OP_CALLIND];
    arith1    = op_oh[OP_INC] | op_oh[OP_DEC] | op_oh[OP_COMP];
    path_pc   = st_oh[ST_E2] & calls;
    path_mem  = st_oh[ST_E4] | (st_oh[ST_E3] & op_oh[OP_LOAD]);
    path_mask = (st_oh[ST_E1] & (op_oh[OP_LOAD] | op_oh[OP_STORE] | op_oh[OP_JUMP]))
              | (st_oh[ST_E3] & op_oh[OP_CALL]);
    path_alu  = (st_oh[ST_E1] & op_oh[OP_CLEAR])
              | ((st_oh[ST_E2] | st_oh[ST_E3]) & arith1)
              | (st_oh[ST_E3] & ty_two);
    bus_sel[BUS_ALU]  = path_alu | path_mem;
    bus_sel[BUS_PC]   = path_pc;
    bus_sel[BUS_MASK] = path_mask | path_mem;
    pc_sel      = st_oh[ST_F1] | (st_oh[ST_E1] & calls);
    use_src     = st_oh[ST_E1] & (ty_indirect | ty_two);
    rd_from_bus = st_oh[ST_E2] & ty_one;
    rd_idx      = use_src ? ir_word[SRC_LSB +: FLD_W] : ir_word[DST_LSB +: FLD_W];
  end
endmodule

// File: rtl/ctl_output_decode.sv
module ctl_output_decode
  import ctlout_pkg::*;
#(
  parameter int IR_W    = 32,
  parameter int DST_LSB = 20,
  parameter int SRC_LSB = 16,
  parameter int FLD_W   = 4,
  localparam int NREGS  = 1 << FLD_W
) (
  input  logic [N_STATES-1:0]   st_oh,
  input  logic [N_OPS-1:0]      op_oh,
  input  logic                  ty_indirect,
  input  logic                  ty_one,
  input  logic                  ty_two,
  input  logic [IR_W-1:0]       ir_word,
  output logic                  mar_ld,
  output logic                  mdr_ld,
  output logic [NREGS-1:0]      reg_we,
  output logic                  pc_sel,
  output logic [SHIFT_FN_W-1:0] shift_fn,
  output logic [ALU_FN_W-1:0]   alu_fn,
  output logic                  carry_in,
  output logic [BUS_SEL_W-1:0]  bus_sel,
  output logic [FLD_W-1:0]      rd_idx,
  output logic                  rd_from_bus
);
  ctlout_load_en #(
    .IR_W(IR_W), .DST_LSB(DST_LSB), .FLD_W(FLD_W)
  ) u_load_en (
    .st_oh(st_oh), .op_oh(op_oh), .ir_word(ir_word),
    .mar_ld(mar_ld), .mdr_ld(mdr_ld), .reg_we(reg_we)
  );

  ctlout_func u_func (
    .st_oh(st_oh), .op_oh(op_oh),
    .shift_fn(shift_fn), .alu_fn(alu_fn), .carry_in(carry_in)
  );

  ctlout_sel #(
    .IR_W(IR_W), .DST_LSB(DST_LSB), .SRC_LSB(SRC_LSB), .FLD_W(FLD_W)
  ) u_sel (
    .st_oh(st_oh), .op_oh(op_oh),
    .ty_indirect(ty_indirect), .ty_one(ty_one), .ty_two(ty_two),
    .ir_word(ir_word),
    .pc_sel(pc_sel), .bus_sel(bus_sel), .rd_idx(rd_idx), .rd_from_bus(rd_from_bus)
  );
endmodule

// File: rtl/ctl_output_decode_chk.sv
module ctl_output_decode_chk
  import ctlout_pkg::*;
#(
  parameter int IR_W    = 32,
  parameter int DST_LSB = 20,
  parameter int FLD_W   = 4,
  localparam int NREGS  = 1 << FLD_W
) (
  input logic [N_STATES-1:0]   st_oh,
  input logic [N_OPS-1:0]      op_oh,
  input logic                  ty_indirect,
  input logic                  ty_one,
  input logic                  ty_two,
  input logic [IR_W-1:0]       ir_word,
  input logic                  mar_ld,
  input logic                  mdr_ld,
  input logic [NREGS-1:0]      reg_we,
  input logic                  pc_sel,
  input logic [SHIFT_FN_W-1:0] shift_fn,
  input logic [ALU_FN_W-1:0]   alu_fn,
  input logic                  carry_in,
  input logic [BUS_SEL_W-1:0]  bus_sel,
  input logic [FLD_W-1:0]      rd_idx,
  input logic                  rd_from_bus
);
  logic legal;
  logic unused_in;

  assign legal     = $onehot0(st_oh) && $onehot0(op_oh);
  assign unused_in = ^{ty_indirect, ty_one, ty_two, shift_fn, rd_idx, ir_word};

  always_comb begin
    if (legal) begin
      p_we_onehot_r3: assert ($onehot0(reg_we))
        else $error("reg_we not one-hot");
      if (reg_we != '0) begin
        p_we_dst_r3: assert (reg_we[ir_word[DST_LSB +: FLD_W]])
          else $error("write enable not on destination field");
      end
      if (st_oh[ST_F3] || st_oh[ST_E4]) begin
        p_mar_idle_r1: assert (!mar_ld) else $error("mar_ld outside its cycles");
      end
      if (st_oh[ST_E3]) begin
        p_mdr_e3_r2: assert (mdr_ld) else $error("mdr_ld missing in E3");
      end
      if (carry_in) begin
        p_cin_inc_r6: assert (alu_fn == 3'b011 && st_oh[ST_E3])
          else $error("carry_in without increment function");
      end
      if (bus_sel[BUS_PC]) begin
        p_pc_path_excl_r7: assert (!bus_sel[BUS_ALU] && !bus_sel[BUS_MASK])
          else $error("pc bus path mixed with another source");
      end
      if (pc_sel) begin
        p_pcsel_state_r9: assert (st_oh[ST_F1] || st_oh[ST_E1])
          else $error("pc_sel outside F1/E1");
      end
      if (st_oh == '0) begin
        p_idle_zero_r10: assert (!mar_ld && !mdr_ld && reg_we == '0 && !pc_sel
                                 && alu_fn == '0 && !carry_in && bus_sel == '0
                                 && !rd_from_bus)
          else $error("state-gated output active with no state");
      end
    end
  end
endmodule

bind ctl_output_decode ctl_output_decode_chk #(
  .IR_W(IR_W), .DST_LSB(DST_LSB), .FLD_W(FLD_W)
) u_chk (.*);

// File: tb/ctl_output_decode_tb.sv
module ctl_output_decode_tb;
  import ctlout_pkg::*;

  localparam int NREGS = 16;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic [N_STATES-1:0] st_oh;
  logic [N_OPS-1:0]    op_oh;
  logic                ty_indirect, ty_one, ty_two;
  logic [31:0]         ir_word;
  logic                mar_ld, mdr_ld, pc_sel, carry_in, rd_from_bus;
  logic [NREGS-1:0]    reg_we;
  logic [1:0]          shift_fn;
  logic [2:0]          alu_fn, bus_sel;
  logic [3:0]          rd_idx;

  ctl_output_decode u_dut (.*);

  int  n_chk  = 0;
  int  n_fail = 0;
  int  cur_si = -1;
  int  cur_oi = -1;
  bit  done   = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s state=%0d op=%0d actual=%h expected=%h", tag, cur_si, cur_oi, act, exp);
    end
  endtask

  function automatic bit is_op(int k, int a, int b = -9, int c = -9, int d = -9,
                               int e = -9, int f = -9);
    return (k >= 0) && (k == a || k == b || k == c || k == d || k == e || k == f);
  endfunction

  // Behavioural reference, compared every falling edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin : ref_model
      int s, o;
      bit e1, e2, e3, e4, wr, pth_pc, pth_mem, pth_mask, pth_alu;
      logic [NREGS-1:0] x_we;
      logic [2:0] x_alu;
      s = cur_si; o = cur_oi;
      e1 = (s == ST_E1); e2 = (s == ST_E2); e3 = (s == ST_E3); e4 = (s == ST_E4);
      chk("R1 mar_ld", 32'(mar_ld), 32'(s == ST_F1 || e1 || e2));
      chk("R2 mdr_ld", 32'(mdr_ld), 32'(s == ST_F2 || e3 || (e2 && o == OP_LOAD)));
      wr = e4 || (e3 && is_op(o, OP_LOAD, OP_ADD, OP_INC, OP_DEC, OP_COMP))
              || (e2 && is_op(o, OP_ASL, OP_MOVE, OP_CALL, OP_CALLIND))
              || (e1 && o == OP_CLEAR);
      x_we = '0;
      if (wr) x_we[ir_word[23:20]] = 1'b1;
      chk("R3 reg_we", 32'(reg_we), 32'(x_we));
      chk("R4 shift_fn", 32'(shift_fn),
          32'({is_op(o, OP_ASR, OP_ROR), is_op(o, OP_ASL, OP_ROR)}));
      x_alu = 3'b000;
      if (e2 && is_op(o, OP_COMP, OP_DEC)) x_alu = 3'b111;
      if (e3) x_alu = {is_op(o, OP_COMP, OP_OR, OP_AND),
                       is_op(o, OP_SUB, OP_COMPARE, OP_DEC, OP_INC, OP_ADD, OP_AND),
                       is_op(o, OP_DEC, OP_INC, OP_ADD, OP_OR)};
      chk("R5 alu_fn", 32'(alu_fn), 32'(x_alu));
      chk("R6 carry_in", 32'(carry_in), 32'(e3 && o == OP_INC));
      pth_pc   = e2 && is_op(o, OP_CALL, OP_CALLIND);
      pth_mem  = e4 || (e3 && o == OP_LOAD);
      pth_mask = (e1 && is_op(o, OP_LOAD, OP_STORE, OP_JUMP)) || (e3 && o == OP_CALL);
      pth_alu  = (e1 && o == OP_CLEAR) || ((e2 || e3) && is_op(o, OP_INC, OP_DEC, OP_COMP))
              || (e3 && ty_two);
      chk("R7 bus_sel", 32'(bus_sel), 32'({pth_mask || pth_mem, pth_pc, pth_alu || pth_mem}));
      chk("R8 rd_idx", 32'(rd_idx),
          32'((e1 && (ty_indirect || ty_two)) ? ir_word[19:16] : ir_word[23:20]));
      chk("R8 rd_from_bus", 32'(rd_from_bus), 32'(e2 && ty_one));
      chk("R9 pc_sel", 32'(pc_sel), 32'(s == ST_F1 || (e1 && is_op(o, OP_CALL, OP_CALLIND))));
      if (s < 0)
        chk("R10 idle outputs", 32'({mar_ld, mdr_ld, pc_sel, carry_in, rd_from_bus,
                                     alu_fn, bus_sel, reg_we}), 32'd0);
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'h1234_5678;
    rst_n = 1'b0;
    st_oh = '0; op_oh = '0; ty_indirect = 0; ty_one = 0; ty_two = 0; ir_word = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);   // R10 reset-state checks with all inputs zero
    for (int si = -1; si < N_STATES; si++) begin
      for (int oi = -1; oi < N_OPS; oi++) begin
        for (int fl = 0; fl < 8; fl++) begin
          @(posedge clk);
          #1;
          seed        = seed * 32'd1103515245 + 32'd12345;
          cur_si      = si;
          cur_oi      = oi;
          st_oh       = (si < 0) ? '0 : N_STATES'(1) << si;
          op_oh       = (oi < 0) ? '0 : N_OPS'(1) << oi;
          ty_indirect = fl[0];
          ty_one      = fl[1];
          ty_two      = fl[2];
          ir_word     = seed;
        end
      end
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule